// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block steers a small 32-bit core into and out of its exception handlers. Six event sources are watched: a fast and a normal external interrupt request (level inputs), a software-trap strobe, an undefined-instruction flag, and abort flags for instruction fetch and data access. At an instruction boundary (`insn_done` high), the highest-priority pending event is accepted. Acceptance does four things. It redirects the program counter to that event's fixed vector. It switches the status register to the event's mode. It writes the interrupted address plus 8 into the destination mode's link register. It copies the old status into that mode's saved-status register.

The block holds the 8-bit status register itself. It also holds one link/saved-status pair for each privileged mode, plus the code of the event that last filled each pair. A return request reads the pair of the current mode. It reloads the status from the saved copy and sends the program counter to the stored link value adjusted by the offset of that event type. The core's datapath can overwrite the status register through a load port. All results are registered and appear one clock after the deciding edge.

Status layout: bits [4:0] hold the mode code, bit 6 masks the fast interrupt, and bit 7 masks the normal interrupt (1 = blocked). Bit 5 is carried unchanged. The mode codes are user 5'h10, fast 5'h11, normal 5'h12, supervisor 5'h13, abort 5'h17 and undefined 5'h1B.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, `psr` reads 8'hD3 (supervisor, both masks set), `taken`, `pc_load`, `lnk_we` and `spsr_we` are 0, and every banked register is zero, so a return issued right after reset yields `pc_next` = 0 and `psr` = 8'h00.
- R2: An accepted event loads `pc_next` with its vector and sets the mode: data abort (code 1) 16 and mode 5'h17, fast interrupt (code 2) 28 and 5'h11, normal interrupt (code 3) 24 and 5'h12, instruction abort (code 4) 12 and 5'h17, undefined instruction (code 5) 4 and 5'h1B, software trap (code 6) 8 and 5'h13.
- R3: When several events are pending in one cycle, the event taken follows the order data abort, fast interrupt, normal interrupt, instruction abort, undefined instruction, software trap.
- R4: On entry, `lnk_we` and `spsr_we` pulse, `lnk_wdata` equals `cur_pc` + 8, and the destination mode's pair stores that value together with the status held before entry.
- R5: A fast-interrupt entry sets bit 6 and a normal-interrupt entry sets bit 7 of the status. Both leave the other mask bit and bit 5 as they were. Other events leave both mask bits unchanged.
- R6: An external request whose mask bit is 1 is not taken. If the request is still held when the mask is cleared, it is taken at the next boundary.
- R7: No event and no return is accepted in a cycle where `insn_done` is low.
- R8: A return sets `pc_next` to the stored link value minus 4 after a fast interrupt, normal interrupt or instruction abort, minus 8 after a data abort, and minus 0 after a software trap or undefined instruction.
- R9: A return restores `psr` from the current mode's saved copy. Nested entries into different modes unwind in reverse order through their own pairs.
- R10: `taken` is high for exactly one cycle per accepted event, with `event_code` giving the event. A return raises `pc_load` without `taken`. A return request in user mode has no effect.
- R11: `psr_wr` loads `psr_wdata` into the status register when no event or return is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_done | input | 1 | Instruction boundary; events and returns are sampled only here |
| fiq_req | input | 1 | Fast interrupt request, level |
| irq_req | input | 1 | Normal interrupt request, level |
| swi_strobe | input | 1 | Software trap |
| undef_flag | input | 1 | Undefined instruction |
| iabort_flag | input | 1 | Instruction fetch abort |
| dabort_flag | input | 1 | Data access abort |
| ret_req | input | 1 | Exception return request |
| cur_pc | input | 32 | Address of the current instruction |
| psr_wr | input | 1 | Status register load from the core |
| psr_wdata | input | 8 | Status value to load |
| psr | output | 8 | Current status register |
| pc_load | output | 1 | Program counter redirect strobe |
| pc_next | output | 32 | New program counter (vector or return address) |
| taken | output | 1 | One-cycle pulse on event entry |
| event_code | output | 3 | Code of the accepted event |
| lnk_we | output | 1 | Link register of `bank_sel` was written |
| spsr_we | output | 1 | Saved status of `bank_sel` was written |
| bank_sel | output | 3 | Bank written: 0 fast, 1 normal, 2 supervisor, 3 abort, 4 undefined |
| lnk_wdata | output | 32 | Value written to the link register |

## Verification
Every output is a register loaded on the edge that samples `insn_done`, so a stimulus applied before edge N shows its results (vector, status, write pulses, return address) in the cycle after edge N. The bench drives inputs on falling edges and reads results on the next falling edge, exactly one rising edge later. Status loads are given their own cycle ahead of the event they precede, because the mask is evaluated from the status held before the edge. Nested-return checks read each return's address and restored status one edge after each `ret_req` cycle.

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int AW = 32,
  parameter int NB = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_done,
  input  logic          fiq_req,
  input  logic          irq_req,
  input  logic          swi_strobe,
  input  logic          undef_flag,
  input  logic          iabort_flag,
  input  logic          dabort_flag,
  input  logic          ret_req,
  input  logic [AW-1:0] cur_pc,
  input  logic          psr_wr,
  input  logic [7:0]    psr_wdata,
  output logic [7:0]    psr,
  output logic          pc_load,
  output logic [AW-1:0] pc_next,
  output logic          taken,
  output logic [2:0]    event_code,
  output logic          lnk_we,
  output logic          spsr_we,
  output logic [2:0]    bank_sel,
  output logic [AW-1:0] lnk_wdata
);
  localparam int FM = 6;
  localparam int IM = 7;
  localparam logic [2:0] NOBANK = 3'd7;
  localparam logic [7:0] PSR_RST = 8'hD3;

  function automatic logic [4:0] mode_of(input logic [2:0] c);
    case (c)
      3'd1, 3'd4: mode_of = 5'h17;
      3'd2:       mode_of = 5'h11;
      3'd3:       mode_of = 5'h12;
      3'd5:       mode_of = 5'h1B;
      default:    mode_of = 5'h13;
    endcase
  endfunction

  function automatic logic [AW-1:0] vec_of(input logic [2:0] c);
    case (c)
      3'd1:    vec_of = AW'(16);
      3'd2:    vec_of = AW'(28);
      3'd3:    vec_of = AW'(24);
      3'd4:    vec_of = AW'(12);
      3'd5:    vec_of = AW'(4);
      default: vec_of = AW'(8);
    endcase
  endfunction

  function automatic logic [AW-1:0] off_of(input logic [2:0] c);
    case (c)
      3'd1:             off_of = AW'(8);
      3'd2, 3'd3, 3'd4: off_of = AW'(4);
      default:          off_of = '0;
    endcase
  endfunction

  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      5'h11:   bank_of = 3'd0;
      5'h12:   bank_of = 3'd1;
      5'h13:   bank_of = 3'd2;
      5'h17:   bank_of = 3'd3;
      5'h1B:   bank_of = 3'd4;
      default: bank_of = NOBANK;
    endcase
  endfunction

  logic [AW-1:0] lnk_q [NB];
  logic [7:0]    sps_q [NB];
  logic [2:0]    evc_q [NB];
  logic [2:0]    sel;

  wire fiq_pend = fiq_req & ~psr[FM];
  wire irq_pend = irq_req & ~psr[IM];

  always_comb begin
    if      (dabort_flag) sel = 3'd1;
    else if (fiq_pend)    sel = 3'd2;
    else if (irq_pend)    sel = 3'd3;
    else if (iabort_flag) sel = 3'd4;
    else if (undef_flag)  sel = 3'd5;
    else if (swi_strobe)  sel = 3'd6;
    else                  sel = 3'd0;
  end

  wire       fire   = insn_done && (sel != 3'd0);
  wire [2:0] cur_b  = bank_of(psr[4:0]);
  wire [2:0] rd_b   = (cur_b == NOBANK) ? 3'd0 : cur_b;
  wire       ret_ok = insn_done && ret_req && !fire && (cur_b != NOBANK);
  wire [2:0] dst_b  = bank_of(mode_of(sel));

  logic [7:0] psr_ent;
  always_comb begin
    psr_ent = {psr[7:5], mode_of(sel)};
    if (sel == 3'd2) psr_ent[FM] = 1'b1;
    if (sel == 3'd3) psr_ent[IM] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psr        <= PSR_RST;
      pc_load    <= 1'b0;
      pc_next    <= '0;
      taken      <= 1'b0;
      event_code <= 3'd0;
      lnk_we     <= 1'b0;
      spsr_we    <= 1'b0;
      bank_sel   <= 3'd0;
      lnk_wdata  <= '0;
      for (int i = 0; i < NB; i++) begin
        lnk_q[i] <= '0;
        sps_q[i] <= '0;
        evc_q[i] <= '0;
      end
    end else begin
      pc_load <= fire || ret_ok;
      taken   <= fire;
      lnk_we  <= fire;
      spsr_we <= fire;
      if (fire) begin
        psr          <= psr_ent;
        pc_next      <= vec_of(sel);
        event_code   <= sel;
        bank_sel     <= dst_b;
        lnk_wdata    <= cur_pc + AW'(8);
        lnk_q[dst_b] <= cur_pc + AW'(8);
        sps_q[dst_b] <= psr;
        evc_q[dst_b] <= sel;
      end else if (ret_ok) begin
        psr        <= sps_q[rd_b];
        pc_next    <= lnk_q[rd_b] - off_of(evc_q[rd_b]);
        event_code <= 3'd0;
      end else begin
        event_code <= 3'd0;
        if (psr_wr) psr <= psr_wdata;
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_done,
  input logic [7:0]  psr,
  input logic        pc_load,
  input logic [31:0] pc_next,
  input logic        taken,
  input logic [2:0]  event_code,
  input logic        lnk_we,
  input logic        spsr_we,
  input logic [2:0]  bank_sel
);
  assert_entry_writes_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (lnk_we && spsr_we && pc_load));

  assert_boundary_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(insn_done) |-> !pc_load);

  assert_fast_sets_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && event_code == 3'd2) |-> (psr[6] && psr[4:0] == 5'h11 && bank_sel == 3'd0));

  assert_normal_sets_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && event_code == 3'd3) |-> (psr[7] && psr[4:0] == 5'h12 && bank_sel == 3'd1));

  assert_code_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (event_code != 3'd0 && event_code != 3'd7));

  assert_return_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !taken) |-> (!lnk_we && !spsr_we));

  assert_vector_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (pc_next[1:0] == 2'b00 && pc_next < 32'd32));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk u_chk (.*);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_done = 1'b0, fiq_req = 1'b0, irq_req = 1'b0;
  logic        swi_strobe = 1'b0, undef_flag = 1'b0, iabort_flag = 1'b0, dabort_flag = 1'b0;
  logic        ret_req = 1'b0, psr_wr = 1'b0;
  logic [31:0] cur_pc = '0;
  logic [7:0]  psr_wdata = '0;
  logic [7:0]  psr;
  logic        pc_load, taken, lnk_we, spsr_we;
  logic [31:0] pc_next, lnk_wdata;
  logic [2:0]  event_code, bank_sel;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_ctrl u_dut (.*);

  // psr load, events {dabort,fiq,irq,iabort,undef,swi}, pc, exp code, exp pc, exp psr
  localparam int NV = 14;
  localparam logic [88:0] VEC [NV] = '{
    {8'h13, 6'b000001, 32'h100, 3'd6, 32'd8,  8'h13},
    {8'h13, 6'b000010, 32'h104, 3'd5, 32'd4,  8'h1B},
    {8'h13, 6'b000100, 32'h108, 3'd4, 32'd12, 8'h17},
    {8'h13, 6'b100000, 32'h10C, 3'd1, 32'd16, 8'h17},
    {8'h13, 6'b001000, 32'h110, 3'd3, 32'd24, 8'h92},
    {8'h13, 6'b010000, 32'h114, 3'd2, 32'd28, 8'h51},
    {8'h13, 6'b111111, 32'h118, 3'd1, 32'd16, 8'h17},
    {8'h13, 6'b011001, 32'h11C, 3'd2, 32'd28, 8'h51},
    {8'h13, 6'b001110, 32'h120, 3'd3, 32'd24, 8'h92},
    {8'h13, 6'b000111, 32'h124, 3'd4, 32'd12, 8'h17},
    {8'h13, 6'b000011, 32'h128, 3'd5, 32'd4,  8'h1B},
    {8'hD3, 6'b011001, 32'h12C, 3'd6, 32'd8,  8'hD3},
    {8'h93, 6'b011000, 32'h130, 3'd2, 32'd28, 8'hD1},
    {8'h53, 6'b011000, 32'h134, 3'd3, 32'd24, 8'hD2}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle;
    insn_done = 0; fiq_req = 0; irq_req = 0; swi_strobe = 0; undef_flag = 0;
    iabort_flag = 0; dabort_flag = 0; ret_req = 0; psr_wr = 0;
  endtask

  task automatic do_reset;
    idle();
    rst_n = 0;
    tick();
    rst_n = 1;
    tick();
  endtask

  task automatic load_psr(input logic [7:0] v);
    idle(); psr_wr = 1; psr_wdata = v; tick(); psr_wr = 0;
  endtask

  task automatic set_ev(input logic [5:0] e);
    dabort_flag = e[5]; fiq_req = e[4]; irq_req = e[3];
    iabort_flag = e[2]; undef_flag = e[1]; swi_strobe = e[0];
  endtask

  task automatic enter(input logic [5:0] e, input logic [31:0] pc);
    idle(); set_ev(e); cur_pc = pc; insn_done = 1; tick(); idle();
  endtask

  task automatic do_ret;
    idle(); ret_req = 1; insn_done = 1; tick(); idle();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    eq("R1 psr", 32'(psr), 32'hD3);
    eq("R1 idle strobes", {28'd0, taken, pc_load, lnk_we, spsr_we}, 32'd0);
    do_ret();
    eq("R1 zero bank pc", pc_next, 32'd0);
    eq("R1 zero bank psr", 32'(psr), 32'h00);
    eq("R10 return not taken", {30'd0, pc_load, taken}, 32'd2);

    // R2 R3 R4 R5 table walk
    for (int i = 0; i < NV; i++) begin
      do_reset();
      load_psr(VEC[i][88:81]);
      enter(VEC[i][80:75], VEC[i][74:43]);
      eq("R3 event_code", 32'(event_code), 32'(VEC[i][42:40]));
      eq("R2 vector", pc_next, VEC[i][39:8]);
      eq("R5 psr after entry", 32'(psr), 32'(VEC[i][7:0]));
      eq("R4 link data", lnk_wdata, VEC[i][74:43] + 32'd8);
      eq("R4 write pulses", {29'd0, taken, lnk_we, spsr_we}, 32'd7);
      tick();
      eq("R10 single pulse", {31'd0, taken}, 32'd0);
    end

    // R7 no acceptance without boundary
    do_reset();
    load_psr(8'h13);
    idle(); set_ev(6'b111111); ret_req = 1; insn_done = 0; tick(); idle();
    eq("R7 nothing without insn_done", {30'd0, taken, pc_load}, 32'd0);
    eq("R7 psr unchanged", 32'(psr), 32'h13);

    // R6 masked request held until unmask
    do_reset();
    idle(); irq_req = 1; insn_done = 1; tick();
    eq("R6 masked not taken", {31'd0, taken}, 32'd0);
    insn_done = 0; psr_wr = 1; psr_wdata = 8'h53; tick();
    psr_wr = 0;
    eq("R11 psr load", 32'(psr), 32'h53);
    insn_done = 1; tick(); idle();
    eq("R6 taken after unmask", {29'd0, taken, event_code}, {29'd0, 1'b1, 3'd3});

    // R8 R9 nested unwind
    do_reset();
    load_psr(8'h13);
    enter(6'b001000, 32'h200);
    eq("R9 irq psr", 32'(psr), 32'h92);
    enter(6'b010000, 32'h300);
    eq("R9 fiq psr", 32'(psr), 32'hD1);
    do_ret();
    eq("R8 fiq return pc", pc_next, 32'h304);
    eq("R9 restore to irq", 32'(psr), 32'h92);
    do_ret();
    eq("R8 irq return pc", pc_next, 32'h204);
    eq("R9 restore to svc", 32'(psr), 32'h13);

    // R8 remaining offsets
    enter(6'b100000, 32'h400); do_ret();
    eq("R8 data abort pc", pc_next, 32'h400);
    eq("R9 data abort psr", 32'(psr), 32'h13);
    enter(6'b000001, 32'h500); do_ret();
    eq("R8 swi pc", pc_next, 32'h508);
    enter(6'b000010, 32'h600); do_ret();
    eq("R8 undef pc", pc_next, 32'h608);
    enter(6'b000100, 32'h700); do_ret();
    eq("R8 iabort pc", pc_next, 32'h704);
    eq("R9 iabort psr", 32'(psr), 32'h13);

    // R10 return in user mode ignored
    load_psr(8'h10);
    do_ret();
    eq("R10 user return no load", {31'd0, pc_load}, 32'd0);
    eq("R10 user psr kept", 32'(psr), 32'h10);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule